// File: doc/BRIEF.md
# Cascadable LCD Segment Row Latch

This block collects one row of display data for a dot-matrix LCD column driver and gives a 2-bit drive-level code for every column. A controller sends the row over a parallel bus that is 4 or 8 bits wide. Each falling edge of a data clock stores one bus word into a first-stage row latch at the position held by a fill pointer. A falling edge of a load strobe copies the whole row into a second-stage latch, and the column outputs are decoded from that latch. The data clock and the load strobe are sampled on the system clock, and their falling edges are found there.

Several instances can share the bus in a chain. An active-low enable is passed from one instance to the next. A direction input chooses which of the two enable pins is the input and which is the output. The same input sets whether the row fills from the first column upwards or from the last column downwards. Each column's level follows its stored bit, a frame alternation input and a display-on input. Changes to the alternation and display-on inputs reach the outputs at once; they do not wait for a load.

Top module: `seg_row_driver`

## Requirements
- R1: With `bus8`=1, each accepted data-clock fall stores `din[7:0]` into the next eight row positions: position p+k receives `din[7-k]`. A row of NCOL columns needs NCOL/8 accepted falls.
- R2: With `bus8`=0, each accepted fall stores `din[3:0]` into the next four positions: position p+k receives `din[3-k]`. `din[7:4]` has no effect, and a row needs NCOL/4 falls.
- R3: With `dir`=0, pin A is the enable input and pin B drives the enable output (`eio_b_oe`=1, `eio_a_oe`=0). With `dir`=1 the roles swap. Both output pins carry the same enable value.
- R4: With `dir`=0, row position p is column p, so the row fills upwards from column 0. With `dir`=1, position p is column NCOL-1-p, so the row fills downwards from the last column.
- R5: While the selected enable input is high, data-clock falls are ignored and the first-stage row stays unchanged.
- R6: The accepted fall that fills the last position drives the enable output low. Later data-clock falls are ignored until a load.
- R7: A load-strobe fall copies the first-stage row into the second stage, resets the fill pointer and drives the enable output high. The column outputs do not change at any other time, except through `m_alt` and `disp_on`.
- R8: When `disp_on`=0, every column outputs code 3, whatever its data and `m_alt`.
- R9: When `disp_on`=1, the code follows the data bit d and `m_alt`: m=1,d=1 gives 0; m=1,d=0 gives 1; m=0,d=0 gives 2; m=0,d=1 gives 3. It changes combinationally with `m_alt` and `disp_on`.
- R10: After reset both latches are all zero, the pointer is at the start and the enable output is high.
- R11: If a load fall and a data fall come in the same cycle, the load takes effect and the data fall is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus8 | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus |
| dir | input | 1 | Selects enable pin roles and fill direction |
| dclk | input | 1 | Data clock; falling edge stores a word |
| ld | input | 1 | Load strobe; falling edge copies the row |
| din | input | 8 | Parallel display data |
| m_alt | input | 1 | Frame alternation |
| disp_on | input | 1 | Display on (low forces code 3) |
| eio_a_in | input | 1 | Enable pin A, input side |
| eio_b_in | input | 1 | Enable pin B, input side |
| eio_a_out | output | 1 | Enable pin A, driven value |
| eio_b_out | output | 1 | Enable pin B, driven value |
| eio_a_oe | output | 1 | Pin A output enable |
| eio_b_oe | output | 1 | Pin B output enable |
| lvl | output | 2*NCOL | Column level codes, column c in bits [2c+1:2c] |

## Verification
The bench builds the block with NCOL=48. A full row is then six words in 8-bit mode and twelve in 4-bit mode. This makes both fill directions, overfilling past the last group, idle periods and a load arriving with a data edge reachable within a few hundred cycles. Because 48 is not a power of two, the pointer limit is tested at a value that does not fall on a natural binary boundary.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int WIDE_W   = 8;
    localparam int NARROW_W = 4;

    typedef enum logic [1:0] {
        LVL_SEL_TOP = 2'd0,
        LVL_UNS_HI  = 2'd1,
        LVL_UNS_LO  = 2'd2,
        LVL_SEL_BOT = 2'd3
    } lvl_e;

    typedef struct packed {
        logic fall_data;
        logic fall_load;
    } strobe_t;

    function automatic lvl_e pick_level(input logic on, input logic m, input logic d);
        lvl_e r;
        if (!on)
            r = LVL_SEL_BOT;
        else if (m)
            r = d ? LVL_SEL_TOP : LVL_UNS_HI;
        else
            r = d ? LVL_SEL_BOT : LVL_UNS_LO;
        return r;
    endfunction

endpackage

// File: rtl/seg_fall_det.sv
module seg_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);
    logic [N-1:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst)
            sig_q <= '0;
        else
            sig_q <= sig;
    end

    assign fall = sig_q & ~sig;
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
    import seg_pkg::*;
#(
    parameter int NCOL = 240,
    parameter int PW   = $clog2(NCOL + WIDE_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dfall,
    input  logic          lfall,
    input  logic          en_n_in,
    input  logic          bus8,
    output logic [PW-1:0] ptr,
    output logic          wr,
    output logic          full,
    output logic          eout_n
);
    logic [PW-1:0] step;
    logic [PW-1:0] ptr_nxt;

    assign step    = bus8 ? PW'(WIDE_W) : PW'(NARROW_W);
    assign ptr_nxt = ptr + step;
    assign wr      = dfall && !lfall && !en_n_in && !full;

    always_ff @(posedge clk) begin
        if (rst || lfall) begin
            ptr    <= '0;
            full   <= 1'b0;
            eout_n <= 1'b1;
        end else if (wr) begin
            ptr <= ptr_nxt;
            if (ptr_nxt >= PW'(NCOL)) begin
                full   <= 1'b1;
                eout_n <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/seg_row_latch.sv
module seg_row_latch #(
    parameter int NCOL = 240,
    parameter int PW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            lfall,
    input  logic            dir,
    input  logic            bus8,
    input  logic [PW-1:0]   ptr,
    input  logic [7:0]      din,
    output logic [NCOL-1:0] l2
);
    logic [NCOL-1:0] l1;
    logic [NCOL-1:0] l1_nxt;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam logic [PW-1:0] POS_UP = PW'(c);
        localparam logic [PW-1:0] POS_DN = PW'(NCOL - 1 - c);
        logic [PW-1:0] pos;
        logic [PW-1:0] off;
        logic          hit;
        logic [2:0]    sel;

        assign pos = dir ? POS_DN : POS_UP;
        assign off = pos - ptr;
        assign hit = wr && (pos >= ptr) && (off < (bus8 ? PW'(8) : PW'(4)));
        assign sel = (bus8 ? 3'd7 : 3'd3) - off[2:0];
        assign l1_nxt[c] = hit ? din[sel] : l1[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l1 <= '0;
            l2 <= '0;
        end else begin
            l1 <= l1_nxt;
            if (lfall)
                l2 <= l1;
        end
    end
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
    import seg_pkg::*;
#(
    parameter int NCOL = 240
) (
    input  logic              disp_on,
    input  logic              m_alt,
    input  logic [NCOL-1:0]   l2,
    output logic [2*NCOL-1:0] lvl
);
    for (genvar c = 0; c < NCOL; c++) begin : g_map
        lvl_e code;
        assign code = pick_level(disp_on, m_alt, l2[c]);
        assign lvl[2*c +: 2] = code;
    end
endmodule

// File: rtl/seg_row_driver.sv
module seg_row_driver
    import seg_pkg::*;
#(
    parameter int NCOL = 240,
    localparam int PW  = $clog2(NCOL + WIDE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus8,
    input  logic              dir,
    input  logic              dclk,
    input  logic              ld,
    input  logic [7:0]        din,
    input  logic              m_alt,
    input  logic              disp_on,
    input  logic              eio_a_in,
    input  logic              eio_b_in,
    output logic              eio_a_out,
    output logic              eio_b_out,
    output logic              eio_a_oe,
    output logic              eio_b_oe,
    output logic [2*NCOL-1:0] lvl
);
    strobe_t         stb;
    logic [1:0]      falls;
    logic            dfall;
    logic            lfall;
    logic            en_n_in;
    logic [PW-1:0]   ptr;
    logic            wr;
    logic            full;
    logic            eout_n;
    logic [NCOL-1:0] l2;

    seg_fall_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .sig  ({dclk, ld}),
        .fall (falls)
    );

    assign stb     = strobe_t'(falls);
    assign dfall   = stb.fall_data;
    assign lfall   = stb.fall_load;
    assign en_n_in = dir ? eio_b_in : eio_a_in;

    seg_fill_ctrl #(.NCOL(NCOL), .PW(PW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .dfall   (dfall),
        .lfall   (lfall),
        .en_n_in (en_n_in),
        .bus8    (bus8),
        .ptr     (ptr),
        .wr      (wr),
        .full    (full),
        .eout_n  (eout_n)
    );

    seg_row_latch #(.NCOL(NCOL), .PW(PW)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .lfall (lfall),
        .dir   (dir),
        .bus8  (bus8),
        .ptr   (ptr),
        .din   (din),
        .l2    (l2)
    );

    seg_level_map #(.NCOL(NCOL)) u_map (
        .disp_on (disp_on),
        .m_alt   (m_alt),
        .l2      (l2),
        .lvl     (lvl)
    );

    assign eio_a_oe  = dir;
    assign eio_b_oe  = ~dir;
    assign eio_a_out = eout_n;
    assign eio_b_out = eout_n;
endmodule

// File: rtl/seg_row_driver_chk.sv
module seg_row_driver_chk #(
    parameter int NCOL = 240,
    parameter int PW   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dir,
    input logic              disp_on,
    input logic              eio_a_in,
    input logic              eio_b_in,
    input logic              eio_a_oe,
    input logic              eio_b_oe,
    input logic              eio_a_out,
    input logic              eio_b_out,
    input logic [2*NCOL-1:0] lvl,
    input logic              dfall,
    input logic              lfall,
    input logic              full,
    input logic [PW-1:0]     ptr,
    input logic [NCOL-1:0]   l2
);
    AST_PIN_ROLES: assert property (@(posedge clk) disable iff (rst)
        $onehot({eio_a_oe, eio_b_oe}) && (eio_a_out == eio_b_out)); // R3

    AST_OFF_FORCES_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        !disp_on |-> (lvl == {NCOL{2'b11}})); // R8

    AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (rst)
        lfall |=> (eio_a_out && ptr == '0 && !full)); // R7

    AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !lfall |=> $stable(l2)); // R7

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (full && !lfall) |=> ($stable(ptr) && !eio_a_out)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((dir ? eio_b_in : eio_a_in) && !lfall) |=> $stable(ptr)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (lfall && dfall) |=> (ptr == '0)); // R11
endmodule

bind seg_row_driver seg_row_driver_chk #(.NCOL(NCOL), .PW(PW)) chk_i (.*);

// File: tb/seg_row_driver_tb_top.sv
`timescale 1ns/1ps
module seg_row_driver_tb_top;
    localparam int NCOL = 48;

    logic clk = 1'b0;
    logic rst, bus8, dir, dclk, ld, m_alt, disp_on, eio_a_in, eio_b_in;
    logic [7:0] din;
    logic eio_a_out, eio_b_out, eio_a_oe, eio_b_oe;
    logic [2*NCOL-1:0] lvl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seg_row_driver #(.NCOL(NCOL)) dut_i (
        .clk(clk), .rst(rst), .bus8(bus8), .dir(dir), .dclk(dclk), .ld(ld),
        .din(din), .m_alt(m_alt), .disp_on(disp_on),
        .eio_a_in(eio_a_in), .eio_b_in(eio_b_in),
        .eio_a_out(eio_a_out), .eio_b_out(eio_b_out),
        .eio_a_oe(eio_a_oe), .eio_b_oe(eio_b_oe), .lvl(lvl)
    );

    // behavioural reference
    bit m_l1 [NCOL];
    bit m_l2 [NCOL];
    int m_ptr;
    bit m_full, m_eout, m_dq, m_lq;

    function automatic int want_code(bit on, bit m, bit d);
        if (!on) return 3;
        if (m) return d ? 0 : 1;
        return d ? 3 : 2;
    endfunction

    function automatic int col_code(int c);
        return int'(lvl[2*c +: 2]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_l1[i]) begin m_l1[i] = 0; m_l2[i] = 0; end
            m_ptr = 0; m_full = 0; m_eout = 1; m_dq = 0; m_lq = 0;
        end else begin
            bit lf, df, en;
            int w;
            lf = m_lq && !ld;
            df = m_dq && !dclk;
            en = dir ? eio_b_in : eio_a_in;
            w  = bus8 ? 8 : 4;
            if (lf) begin
                foreach (m_l2[i]) m_l2[i] = m_l1[i];
                m_ptr = 0; m_full = 0; m_eout = 1;
            end else if (df && !en && !m_full) begin
                for (int k = 0; k < w; k++) begin
                    int p;
                    p = m_ptr + k;
                    m_l1[dir ? NCOL - 1 - p : p] = din[w - 1 - k];
                end
                m_ptr += w;
                if (m_ptr >= NCOL) begin m_full = 1; m_eout = 0; end
            end
            m_dq = dclk; m_lq = ld;
        end
    end

    // per-cycle comparison, away from both edges
    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            int bad;
            bad = -1;
            for (int c = 0; c < NCOL; c++)
                if (col_code(c) != want_code(disp_on, m_alt, m_l2[c]) && bad < 0) bad = c;
            chk(bad < 0, "R7 R8 R9 per-cycle column level",
                bad < 0 ? 0 : col_code(bad),
                bad < 0 ? 0 : want_code(disp_on, m_alt, m_l2[bad]));
            chk(eio_a_out == m_eout && eio_b_out == m_eout && eio_a_oe == dir && eio_b_oe == !dir,
                "R3 R6 per-cycle enable pins", int'(eio_a_out), int'(m_eout));
        end
    end

    task automatic push(input logic [7:0] d);
        @(negedge clk); din = d; dclk = 1'b1;
        @(negedge clk); dclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_load;
        @(negedge clk); ld = 1'b1;
        @(negedge clk); ld = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; bus8 = 1; dir = 0; dclk = 0; ld = 0; din = 0;
        m_alt = 1; disp_on = 1; eio_a_in = 0; eio_b_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10: reset state
        chk(eio_b_out == 1'b1, "R10 enable out high after reset", int'(eio_b_out), 1);
        chk(col_code(0) == 1, "R10 cleared data shows code 1", col_code(0), 1);
        // R3: pin roles, dir=0
        chk(eio_b_oe && !eio_a_oe, "R3 dir0 pin B drives", int'(eio_b_oe), 1);

        // R1 R4: 8-bit upward fill
        push(8'hA5);
        for (int i = 0; i < 5; i++) push(8'h3C);
        chk(eio_b_out == 1'b0, "R6 enable out low when row full", int'(eio_b_out), 0);
        chk(col_code(0) == 1, "R7 outputs unchanged before load", col_code(0), 1);
        push(8'h00); push(8'h00); // R6 ignored after full
        do_load();
        chk(eio_b_out == 1'b1, "R7 enable released by load", int'(eio_b_out), 1);
        chk(col_code(0) == 0, "R1 col0 takes D7", col_code(0), 0);
        chk(col_code(1) == 1, "R1 col1 takes D6", col_code(1), 1);
        chk(col_code(7) == 0, "R4 col7 takes D0", col_code(7), 0);
        chk(col_code(47) == 1, "R6 extra words ignored", col_code(47), 1);

        // R2 R4: 4-bit downward fill
        dir = 1; bus8 = 0;
        @(negedge clk);
        chk(eio_a_oe && !eio_b_oe, "R3 dir1 pin A drives", int'(eio_a_oe), 1);
        push(8'hF9);
        for (int i = 0; i < 11; i++) push(8'hF0);
        chk(eio_a_out == 1'b0, "R6 4-bit row full after 12 words", int'(eio_a_out), 0);
        do_load();
        chk(col_code(47) == 0, "R4 last column takes D3", col_code(47), 0);
        chk(col_code(46) == 1, "R2 col46 takes D2", col_code(46), 1);
        chk(col_code(44) == 0, "R2 col44 takes D0", col_code(44), 0);
        chk(col_code(43) == 1, "R2 upper nibble ignored", col_code(43), 1);

        // R5: idle when enable input high
        eio_b_in = 1;
        for (int i = 0; i < 12; i++) push(8'hFF);
        chk(eio_a_out == 1'b1, "R5 idle device never fills", int'(eio_a_out), 1);
        do_load();
        chk(col_code(0) == 1, "R5 idle data not stored", col_code(0), 1);
        eio_b_in = 0;

        // R9 R8: alternation and display off act directly
        @(negedge clk); m_alt = 0;
        #1;
        chk(col_code(47) == 3, "R9 m0 d1 gives 3", col_code(47), 3);
        chk(col_code(46) == 2, "R9 m0 d0 gives 2", col_code(46), 2);
        @(negedge clk); disp_on = 0;
        #1;
        chk(col_code(46) == 3, "R8 display off forces 3", col_code(46), 3);
        @(negedge clk); disp_on = 1; m_alt = 1;

        // R11: load and data falls coincide
        bus8 = 1; dir = 0;
        push(8'hFF); push(8'hFF);
        @(negedge clk); din = 8'h81; dclk = 1'b1; ld = 1'b1;
        @(negedge clk); dclk = 1'b0; ld = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) push(8'h81);
        chk(eio_b_out == 1'b1, "R11 data discarded, row not full at 5", int'(eio_b_out), 1);
        push(8'h81);
        chk(eio_b_out == 1'b0, "R11 row full at 6", int'(eio_b_out), 0);
        do_load();
        chk(col_code(0) == 0 && col_code(1) == 1, "R11 fresh row after load", col_code(1), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule